// File: doc/BRIEF.md
# Configurable Comparator and Leading/Trailing Digit Search Tree

This block is a purely combinational binary tree over a 2^DEPTH-bit input word. A single structure serves two jobs. In detector mode it finds a one bit in the word and reports where it sits. The invert control makes it look for a zero bit instead. The flip control turns the priority around, so that the lowest matching bit is found instead of the highest. In comparator mode the input word holds two operands interleaved bit by bit. The tree then finds the most significant digit where the operands differ, or the least significant one when flip is set, and reports which operand holds the one at that digit.

The mode and invert controls act only on the base cells, each of which covers one bit pair. Every combining level adds one 2:1 multiplexer that picks the priority side from the flip control. All outputs pass through DEPTH combinational stages. Positions are always absolute bit indices counted from bit 0, and the position is forced to zero when nothing is found. Typical users are normalisation shifters, incrementers (trailing zero) and decrementers (trailing one), and magnitude compares in an execution unit.

Top module: `cld_tree`

## Requirements
- R1: With cmp_mode=0, invert=0 and flip=0, found is 1 when din has any bit set, and pos is the index of the highest set bit of din.
- R2: With cmp_mode=0, invert=1 and flip=0, found is 1 when din has any clear bit, and pos is the index of the highest clear bit of din.
- R3: With cmp_mode=0, invert=0 and flip=1, pos is the index of the lowest set bit of din. Found is the same as in R1.
- R4: With cmp_mode=0, invert=1 and flip=1, pos is the index of the lowest clear bit of din. Found is the same as in R2.
- R5: Whenever found is 0, pos is all zeros, in every combination of the three controls.
- R6: With cmp_mode=1, operand A bit k is din[2k+1] and operand B bit k is din[2k]. Found is 1 when A differs from B. With invert=0 and flip=0, pos[DEPTH-1:1] is the index k of the most significant differing digit, and pos[0] is 1 when A>B (unsigned).
- R7: With cmp_mode=1, invert=0 and flip=1, pos[DEPTH-1:1] is the index of the least significant digit where A and B differ, and pos[0] is A's bit at that digit.
- R8: With cmp_mode=1 and invert=1, found behaves as without invert. pos[0] is the inverse of A's bit at the chosen digit, so with flip=0 it is 1 when A has a zero at the most significant difference. The digit is chosen by flip as in R6 and R7.
- R9: The tree is built for any DEPTH of at least 1. With DEPTH=1 it is a single base cell with a one-bit position, and it follows R1 to R8 for a 2-bit word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 2**DEPTH | Data word, or two operands interleaved (A on odd bits, B on even bits) |
| cmp_mode | input | 1 | 1 selects comparator mode, 0 selects digit detection |
| invert | input | 1 | 1 complements every data bit before the search |
| flip | input | 1 | 1 gives the lowest position priority instead of the highest |
| found | output | 1 | A matching digit exists (comparator: operands differ) |
| pos | output | DEPTH | Absolute bit index of the selected digit, zero when found is 0 |

## Verification
The bench builds the tree with DEPTH=4, a 16-bit word. That word is small enough to sweep all 65536 values under each of the eight combinations of mode, invert and flip, against reference scans that work bit by bit. It also builds a second copy with DEPTH=1. That copy is only the base cell, so its mode and flip muxing is checked without any combining level in the way. The sweeps include the all-zero and all-one words, which exercise found=0 and the forced-zero position in every mode.

// File: rtl/cld_pkg.sv
package cld_pkg;

  // search function selected by the mode input
  typedef enum logic {
    SRCH_DETECT  = 1'b0,
    SRCH_COMPARE = 1'b1
  } srch_mode_e;

  // number of base cells for a tree of a given depth
  function automatic int leaf_count(input int depth);
    return (1 << depth) / 2;
  endfunction

endpackage

// File: rtl/cld_leaf.sv
module cld_leaf
  import cld_pkg::*;
(
  input  logic hi_bit,
  input  logic lo_bit,
  input  logic invert,
  input  logic cmp_mode,
  input  logic flip,
  output logic exists,
  output logic pick
);

  logic       hi_eff;
  logic       lo_eff;
  logic       pick_raw;
  srch_mode_e mode;

  always_comb begin
    mode   = srch_mode_e'(cmp_mode);
    hi_eff = hi_bit ^ invert;
    lo_eff = lo_bit ^ invert;
    if (mode == SRCH_COMPARE) begin
      exists   = hi_eff ^ lo_eff;
      pick_raw = hi_eff;
    end else begin
      exists   = hi_eff | lo_eff;
      pick_raw = flip ? ~lo_eff : hi_eff;
    end
    pick = pick_raw & exists;
  end

  // R3
  always_comb begin
    if (!cmp_mode && flip && ((lo_bit ^ invert) == 1'b1)) begin
      leaf_low_first_chk: assert (exists && !pick);
    end
  end

  // R1
  always_comb begin
    if (!cmp_mode && !flip && ((hi_bit ^ invert) == 1'b1)) begin
      leaf_high_first_chk: assert (exists && pick);
    end
  end

endmodule

// File: rtl/cld_merge.sv
module cld_merge #(
  parameter int SUB_W = 1
) (
  input  logic             e_hi,
  input  logic [SUB_W-1:0] p_hi,
  input  logic             e_lo,
  input  logic [SUB_W-1:0] p_lo,
  input  logic             flip,
  output logic             e_out,
  output logic [SUB_W:0]   p_out
);

  logic             top_bit;
  logic [SUB_W-1:0] low_bits;

  always_comb begin
    e_out = e_hi | e_lo;
    if (!flip) begin
      top_bit  = e_hi;
      low_bits = e_hi ? p_hi : p_lo;
    end else begin
      top_bit  = e_hi & ~e_lo;
      low_bits = e_lo ? p_lo : p_hi;
    end
    p_out = {top_bit, low_bits};
  end

  // R5
  always_comb begin
    if (!e_hi && !e_lo) begin
      merge_idle_zero_chk: assert (p_out == '0);
    end
  end

  // R1
  always_comb begin
    if (!flip && e_hi) begin
      merge_upper_wins_chk: assert (p_out[SUB_W] && (p_out[SUB_W-1:0] == p_hi));
    end
  end

  // R3
  always_comb begin
    if (flip && e_lo) begin
      merge_lower_wins_chk: assert (!p_out[SUB_W] && (p_out[SUB_W-1:0] == p_lo));
    end
  end

endmodule

// File: rtl/cld_tree.sv
module cld_tree
  import cld_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic [(1<<DEPTH)-1:0] din,
  input  logic                  cmp_mode,
  input  logic                  invert,
  input  logic                  flip,
  output logic                  found,
  output logic [DEPTH-1:0]      pos
);

  localparam int WIDTH  = 1 << DEPTH;
  localparam int LEAVES = leaf_count(DEPTH);
  localparam int NODES  = 2 * LEAVES;

  // heap layout: node 1 is the root, nodes LEAVES..NODES-1 are base cells,
  // children of node i are 2i (lower half) and 2i+1 (upper half)
  logic             heap_e [1:NODES-1];
  logic [DEPTH-1:0] heap_p [1:NODES-1];

  genvar k;
  generate
    for (k = 0; k < LEAVES; k++) begin : g_leaf
      logic cell_e;
      logic cell_p;
      cld_leaf u_leaf (
        .hi_bit   (din[2*k+1]),
        .lo_bit   (din[2*k]),
        .invert   (invert),
        .cmp_mode (cmp_mode),
        .flip     (flip),
        .exists   (cell_e),
        .pick     (cell_p)
      );
      assign heap_e[LEAVES+k] = cell_e;
      assign heap_p[LEAVES+k] = DEPTH'(cell_p);
    end
  endgenerate

  genvar lv, n;
  generate
    for (lv = 1; lv < DEPTH; lv++) begin : g_level
      for (n = 0; n < (LEAVES >> lv); n++) begin : g_node
        localparam int IDX = (LEAVES >> lv) + n;
        logic          m_e;
        logic [lv:0]   m_p;
        cld_merge #(.SUB_W(lv)) u_merge (
          .e_hi  (heap_e[2*IDX+1]),
          .p_hi  (heap_p[2*IDX+1][lv-1:0]),
          .e_lo  (heap_e[2*IDX]),
          .p_lo  (heap_p[2*IDX][lv-1:0]),
          .flip  (flip),
          .e_out (m_e),
          .p_out (m_p)
        );
        assign heap_e[IDX] = m_e;
        assign heap_p[IDX] = DEPTH'(m_p);
      end
    end
  endgenerate

  assign found = heap_e[1];
  assign pos   = heap_p[1];

  // checks relating the root outputs to the data word
  logic [WIDTH-1:0] eff_word;
  int               pair_base;

  always_comb begin
    eff_word  = din ^ {WIDTH{invert}};
    pair_base = int'(pos) & ~1;
  end

  // R5
  always_comb begin
    if (!found) begin
      idle_pos_zero_chk: assert (pos == '0);
    end
  end

  // R1
  always_comb begin
    if (!cmp_mode) begin
      detect_hit_chk: assert (found ? eff_word[pos] : (eff_word == '0));
    end
  end

  // R6
  always_comb begin
    if (cmp_mode && found) begin
      cmp_pair_differs_chk: assert (eff_word[pair_base] != eff_word[pair_base+1]);
    end
  end

  // R8
  always_comb begin
    if (cmp_mode && found) begin
      cmp_side_bit_chk: assert (pos[0] == eff_word[pair_base+1]);
    end
  end

endmodule

// File: tb/tb_cld_tree.sv
`timescale 1ns/1ps
module tb_cld_tree;

  localparam int DEPTH = 4;
  localparam int WIDTH = 1 << DEPTH;
  localparam int HALF  = WIDTH / 2;

  logic clk;
  logic rst_n;
  initial clk = 1'b0;
  always #5 clk = ~clk;

  logic [WIDTH-1:0] din;
  logic             cmp_mode, invert, flip;
  logic             found;
  logic [DEPTH-1:0] pos;

  logic [1:0]       din_m;
  logic             found_m;
  logic [0:0]       pos_m;

  cld_tree #(.DEPTH(DEPTH)) dut (
    .din(din), .cmp_mode(cmp_mode), .invert(invert), .flip(flip),
    .found(found), .pos(pos)
  );

  cld_tree #(.DEPTH(1)) dut_min (
    .din(din_m), .cmp_mode(cmp_mode), .invert(invert), .flip(flip),
    .found(found_m), .pos(pos_m)
  );

  int total;
  int bad;
  bit finished;

  task automatic check_val(input string tag, input string what,
                           input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d (din=%h mode=%0b inv=%0b flip=%0b)",
               tag, what, act, exp, din, cmp_mode, invert, flip);
    end
  endtask

  // reference: scan an effective word for the highest or lowest set bit
  function automatic void ref_scan(input logic [WIDTH-1:0] w, input int nbits,
                                   input bit low_first, output bit f, output int p);
    f = 1'b0;
    p = 0;
    for (int i = 0; i < nbits; i++) begin
      if (w[i] && (!f || !low_first)) begin
        f = 1'b1;
        p = i;
      end
    end
  endfunction

  task automatic run_detect(input bit inv, input bit fl, input string tag);
    bit f;
    int p;
    for (int v = 0; v < (1 << WIDTH); v++) begin
      din = v[WIDTH-1:0]; cmp_mode = 1'b0; invert = inv; flip = fl;
      #1;
      ref_scan(din ^ {WIDTH{inv}}, WIDTH, fl, f, p);
      check_val(tag, "found", int'(found), int'(f));
      check_val(f ? tag : "R5", "pos", int'(pos), p);
    end
  endtask

  task automatic run_compare(input bit inv, input bit fl, input string tag);
    bit f;
    int k;
    logic [HALF-1:0] opa, opb;
    for (int v = 0; v < (1 << WIDTH); v++) begin
      din = v[WIDTH-1:0]; cmp_mode = 1'b1; invert = inv; flip = fl;
      #1;
      for (int j = 0; j < HALF; j++) begin
        opa[j] = din[2*j+1];
        opb[j] = din[2*j];
      end
      ref_scan(WIDTH'(opa ^ opb), HALF, fl, f, k);
      check_val(tag, "found", int'(found), int'(f));
      if (f) check_val(tag, "pos", int'(pos), 2*k + int'(opa[k] ^ inv));
      else   check_val("R5", "pos", int'(pos), 0);
      if (!inv && !fl && f) check_val("R6", "a_greater", int'(pos[0]), int'(opa > opb));
    end
  endtask

  task automatic run_min_depth();
    bit f;
    int p;
    for (int c = 0; c < 8; c++) begin
      for (int v = 0; v < 4; v++) begin
        din_m = v[1:0]; cmp_mode = c[2]; invert = c[1]; flip = c[0];
        #1;
        if (c[2]) begin
          f = din_m[1] ^ din_m[0];
          p = f ? int'(din_m[1] ^ c[1]) : 0;
        end else begin
          ref_scan(WIDTH'(din_m ^ {2{c[1]}}), 2, c[0], f, p);
        end
        check_val("R9", "found_min", int'(found_m), int'(f));
        check_val("R9", "pos_min", int'(pos_m), p);
      end
    end
  endtask

  task automatic check_reset_state();
    din = '0; din_m = '0; cmp_mode = 1'b0; invert = 1'b0; flip = 1'b0;
    @(negedge clk);
    check_val("R5", "reset_found", int'(found), 0);
    check_val("R5", "reset_pos", int'(pos), 0);
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    total = 0; bad = 0; finished = 1'b0;
    rst_n = 1'b0;
    din = '0; din_m = '0; cmp_mode = 1'b0; invert = 1'b0; flip = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_reset_state();
    run_detect(1'b0, 1'b0, "R1");
    run_detect(1'b1, 1'b0, "R2");
    run_detect(1'b0, 1'b1, "R3");
    run_detect(1'b1, 1'b1, "R4");
    run_compare(1'b0, 1'b0, "R6");
    run_compare(1'b0, 1'b1, "R7");
    run_compare(1'b1, 1'b0, "R8");
    run_compare(1'b1, 1'b1, "R8");
    run_min_depth();
    finished = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      report();
      $finish;
    end
  end

endmodule